// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital side of a dual-slope integrating analog-to-digital converter. A one-cycle start request launches a conversion. The block connects the integrator to the unknown input for a fixed run of `T_CNT` clock cycles. It then connects the integrator to a reference of opposite polarity. It counts clock cycles until the comparator reports that the integrator has returned to zero. That count is the binary result. A full-scale input, equal to the reference, yields exactly `T_CNT`.

After the count stops, the integrator capacitor is shorted for a fixed number of cycles and the block goes idle. If the integrator has not returned to zero after `2*T_CNT` reference cycles, the conversion is abandoned, the result saturates at `2*T_CNT` and an overrange flag is raised. Choose `T_CNT` so that the input phase spans a whole number of mains periods. This gives good rejection of 50 Hz and 60 Hz ripple.

Top module: `dslope_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, all three switch selects are low, `done_o` is low, and `result_o` and `ovr_o` read zero.
- R2: A start pulse seen in idle drives `sel_in_o` high from the next cycle, for exactly `T_CNT` consecutive cycles.
- R3: When `sel_in_o` falls, `sel_ref_o` rises in the same cycle. The counter restarts at zero and counts the reference cycles applied. Counting stops on the first cycle in which `cmp_hi_i` is low. The result equals the number of reference cycles applied before that cycle: ceil(input charge / reference step).
- R4: An input equal to the reference gives a result of exactly `T_CNT`. A zero input gives a result of 0, with no reference cycle applied.
- R5: If `cmp_hi_i` is still high when the reference count reaches `2*T_CNT`, the result is `2*T_CNT` and `ovr_o` is 1. If the zero crossing shows on exactly that cycle, the result is `2*T_CNT` and `ovr_o` is 0.
- R6: `done_o` is a single-cycle pulse. `result_o` and `ovr_o` carry the new values in the pulse cycle and hold them until the next pulse.
- R7: `sel_clr_o` is high for exactly `CLR_CYC` cycles. It starts in the `done_o` cycle, after which the block is idle with all selects low.
- R8: A start pulse during the input, reference or clear phase has no effect. It does not stretch the input phase, does not change the result, and does not start a new conversion after the clear phase.
- R9: At most one of `sel_in_o`, `sel_ref_o`, `sel_clr_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all counting is in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Conversion request, sampled only in idle |
| cmp_hi_i | input | 1 | Comparator: high while the integrator has not yet returned to zero |
| sel_in_o | output | 1 | Connects the unknown input to the integrator |
| sel_ref_o | output | 1 | Connects the opposite-polarity reference to the integrator |
| sel_clr_o | output | 1 | Shorts the integrator capacitor |
| result_o | output | $clog2(2*T_CNT+1) | Reference cycle count of the last conversion |
| done_o | output | 1 | One-cycle pulse when a new result is registered |
| ovr_o | output | 1 | Last conversion hit the overrange limit |

## Verification
Two of the block's functions can fall in the same cycle: the zero-crossing stop and the overrange limit. The bench provokes this with an input of exactly twice the reference. The comparator then drops on the very cycle the count reaches `2*T_CNT`. The check expects a saturated count with the overrange flag clear. One step more input must set the flag.

A second collision is a start request that lands during a busy phase, including the clear phase just before idle. It is judged by the unchanged input-phase length, the unchanged result, and the selects staying low after the clear phase.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_INTEG = 2'd1,
    PH_DEINT = 2'd2,
    PH_CLEAR = 2'd3
  } phase_e;
endpackage

// File: rtl/dsc_rst_sync.sv
module dsc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/dsc_counter.sv
module dsc_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (clr | en) cnt <= cnt_d;
  end
endmodule

// File: rtl/dsc_fsm.sv
module dsc_fsm
  import dsc_pkg::*;
#(
  parameter int T_CNT   = 40,
  parameter int CLR_CYC = 4,
  parameter int CW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cmp_hi,
  input  logic [CW-1:0] cnt,
  output phase_e        phase,
  output logic          cnt_clr,
  output logic          cnt_en,
  output logic          cap_en,
  output logic          cap_ovr
);
  localparam logic [CW-1:0] T_LAST   = CW'(T_CNT - 1);
  localparam logic [CW-1:0] REF_MAX  = CW'(2 * T_CNT);
  localparam logic [CW-1:0] CLR_LAST = CW'(CLR_CYC - 1);

  phase_e phase_d;

  always_comb begin
    phase_d = phase;
    cnt_clr = 1'b0;
    cnt_en  = 1'b0;
    cap_en  = 1'b0;
    cap_ovr = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_INTEG;
          cnt_clr = 1'b1;
        end
      end
      PH_INTEG: begin
        if (cnt == T_LAST) begin
          phase_d = PH_DEINT;
          cnt_clr = 1'b1;
        end else begin
          cnt_en = 1'b1;
        end
      end
      PH_DEINT: begin
        if (!cmp_hi || (cnt == REF_MAX)) begin
          phase_d = PH_CLEAR;
          cnt_clr = 1'b1;
          cap_en  = 1'b1;
          cap_ovr = cmp_hi;
        end else begin
          cnt_en = 1'b1;
        end
      end
      PH_CLEAR: begin
        if (cnt == CLR_LAST) begin
          phase_d = PH_IDLE;
          cnt_clr = 1'b1;
        end else begin
          cnt_en = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_d;
  end
endmodule

// File: rtl/dsc_result.sv
module dsc_result #(
  parameter int RW = 7,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic          cap_ovr,
  input  logic [CW-1:0] cnt,
  output logic [RW-1:0] result,
  output logic          ovr,
  output logic          done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= cap_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      ovr    <= 1'b0;
    end else if (cap_en) begin
      result <= cnt[RW-1:0];
      ovr    <= cap_ovr;
    end
  end
endmodule

// File: rtl/dslope_ctrl.sv
module dslope_ctrl
  import dsc_pkg::*;
#(
  parameter int T_CNT   = 40,
  parameter int CLR_CYC = 4,
  parameter int RES_W   = $clog2(2 * T_CNT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_hi_i,
  output logic             sel_in_o,
  output logic             sel_ref_o,
  output logic             sel_clr_o,
  output logic [RES_W-1:0] result_o,
  output logic             done_o,
  output logic             ovr_o
);
  localparam int CLR_W = $clog2(CLR_CYC + 1);
  localparam int CW    = (RES_W > CLR_W) ? RES_W : CLR_W;

  logic          rst_n_int;
  logic [CW-1:0] cnt;
  logic          cnt_clr, cnt_en, cap_en, cap_ovr;
  phase_e        phase;

  dsc_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_int)
  );

  dsc_counter #(.CW(CW)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n_int),
    .clr  (cnt_clr),
    .en   (cnt_en),
    .cnt  (cnt)
  );

  dsc_fsm #(.T_CNT(T_CNT), .CLR_CYC(CLR_CYC), .CW(CW)) u_fsm (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .start  (start_i),
    .cmp_hi (cmp_hi_i),
    .cnt    (cnt),
    .phase  (phase),
    .cnt_clr(cnt_clr),
    .cnt_en (cnt_en),
    .cap_en (cap_en),
    .cap_ovr(cap_ovr)
  );

  dsc_result #(.RW(RES_W), .CW(CW)) u_res (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .cap_en (cap_en),
    .cap_ovr(cap_ovr),
    .cnt    (cnt),
    .result (result_o),
    .ovr    (ovr_o),
    .done   (done_o)
  );

  assign sel_in_o  = (phase == PH_INTEG);
  assign sel_ref_o = (phase == PH_DEINT);
  assign sel_clr_o = (phase == PH_CLEAR);
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
  parameter int T_CNT   = 40,
  parameter int CLR_CYC = 4,
  parameter int RES_W   = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel_in_o,
  input logic             sel_ref_o,
  input logic             sel_clr_o,
  input logic [RES_W-1:0] result_o,
  input logic             done_o,
  input logic             ovr_o
);
  int unsigned in_run, clr_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_run  <= 0;
      clr_run <= 0;
    end else begin
      in_run  <= sel_in_o  ? in_run + 1  : 0;
      clr_run <= sel_clr_o ? clr_run + 1 : 0;
    end
  end

  assert_sel_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_in_o, sel_ref_o, sel_clr_o}));

  assert_in_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_in_o && $past(sel_in_o)) |-> (in_run == T_CNT));

  assert_ref_follows_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_ref_o) |-> $past(sel_in_o));

  assert_start_from_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_in_o) |-> $past(!sel_ref_o && !sel_clr_o));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(result_o) && $stable(ovr_o)));

  assert_ovr_saturates_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && ovr_o) |-> (result_o == RES_W'(2 * T_CNT)));

  assert_clear_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> sel_clr_o);

  assert_clear_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_clr_o && $past(sel_clr_o)) |-> (clr_run == CLR_CYC));
endmodule

bind dslope_ctrl dsc_checker #(.T_CNT(T_CNT), .CLR_CYC(CLR_CYC), .RES_W(RES_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sel_in_o (sel_in_o),
  .sel_ref_o(sel_ref_o),
  .sel_clr_o(sel_clr_o),
  .result_o (result_o),
  .done_o   (done_o),
  .ovr_o    (ovr_o)
);

// File: tb/tb_dslope_ctrl.sv
module tb_dslope_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TI    = 40;
  localparam int CLR   = 4;
  localparam int RW    = $clog2(2 * TI + 1);
  localparam int NVEC  = 11;
  localparam int STEP  = 8;

  // {input step, expected result, expected overrange}
  localparam int VEC [NVEC][3] = '{
    '{8,  40, 0}, '{0,   0, 0}, '{4,  20, 0}, '{3,  15, 0},
    '{5,  25, 0}, '{1,   5, 0}, '{7,  35, 0}, '{13, 65, 0},
    '{9,  45, 0}, '{16, 80, 0}, '{17, 80, 1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          cmp_hi_i;
  logic          sel_in_o, sel_ref_o, sel_clr_o, done_o, ovr_o;
  logic [RW-1:0] result_o;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  int vin   = 0;
  int charge;

  dslope_ctrl #(.T_CNT(TI), .CLR_CYC(CLR)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .cmp_hi_i (cmp_hi_i),
    .sel_in_o (sel_in_o),
    .sel_ref_o(sel_ref_o),
    .sel_clr_o(sel_clr_o),
    .result_o (result_o),
    .done_o   (done_o),
    .ovr_o    (ovr_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // integrator model in integer charge units
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)         charge <= 0;
    else if (sel_clr_o) charge <= 0;
    else if (sel_in_o)  charge <= charge + vin;
    else if (sel_ref_o) charge <= charge - STEP;
  end
  assign cmp_hi_i = (charge > 0);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests = tests + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    check(req, {29'd0, sel_in_o, sel_ref_o, sel_clr_o}, 0);
  endtask

  // mid: 0 none, 1 start pulse during input phase, 2 during reference phase, 3 during clear phase
  task automatic convert(input int v, input int exp_res, input int exp_ovr, input int mid);
    int n_in, n_clr, n_done, guard;
    vin = v;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    check("R2 input phase begins", int'(sel_in_o), 1);
    n_in = 0;
    while (sel_in_o && n_in < 4 * TI) begin
      n_in++;
      start_i = (mid == 1 && n_in == 6);
      @(negedge clk);
    end
    start_i = 1'b0;
    check("R2 input phase length", n_in, TI);
    check("R3 reference follows input", int'(sel_ref_o || done_o), 1);
    guard = 0;
    while (!done_o && guard < 4 * TI) begin
      guard++;
      start_i = (mid == 2 && guard == 2);
      @(negedge clk);
    end
    start_i = 1'b0;
    check("R3 R4 result", int'(result_o), exp_res);
    check("R5 overrange flag", int'(ovr_o), exp_ovr);
    check("R7 clear with done", int'(sel_clr_o), 1);
    n_clr = 0;
    n_done = 0;
    while (sel_clr_o && n_clr < 4 * CLR) begin
      n_clr++;
      if (done_o) n_done++;
      start_i = (mid == 3 && n_clr == CLR);
      @(negedge clk);
    end
    start_i = 1'b0;
    check("R7 clear length", n_clr, CLR);
    check("R6 done single pulse", n_done, 1);
    for (int k = 0; k < 3; k++) begin
      check_idle("R7 R8 idle after clear");
      @(negedge clk);
    end
    check("R6 result held", int'(result_o), exp_res);
  endtask

  initial begin
    #1;
    check_idle("R1 selects in reset");
    check("R1 result in reset", int'(result_o), 0);
    check("R1 done and ovr in reset", int'({done_o, ovr_o}), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R1 idle after release");
    check("R1 result after release", int'(result_o), 0);

    for (int i = 0; i < NVEC; i++) begin
      convert(VEC[i][0], VEC[i][1], VEC[i][2], 0);
    end

    // R8: start requests while busy are ignored
    convert(5, 25, 0, 1);
    convert(13, 65, 0, 2);
    convert(3, 15, 0, 3);

    // R5: overrange flag clears on the next in-range result
    convert(20, 80, 1, 0);
    convert(2, 10, 0, 0);

    // R1: reset in the middle of the reference phase
    vin = 6;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    repeat (TI + 5) @(negedge clk);
    check("R3 in reference phase", int'(sel_ref_o), 1);
    rst_n = 1'b0;
    #1;
    check_idle("R1 selects on mid reset");
    check("R1 result on mid reset", int'(result_o), 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R1 idle after mid reset");
    convert(4, 20, 0, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule